// File: doc/BRIEF.md
# Decimal Packed-Digit Adder/Subtractor

This block takes two unsigned decimal operands, each held as packed 4-bit digits (three digits by default), and either adds them or subtracts the second from the first. Subtraction works in decimal throughout. Each digit of the subtrahend is replaced by its nines' complement, the sum is formed digit by digit with a decimal correction, and the carry that leaves the top digit is either added back at the bottom or used to mark a negative result. One digit is processed per clock, with the carry held in a register from one digit to the next.

An operation is offered on a valid/ready input. `in_ready` is high only while the block is idle. A source that sees it low must hold `in_valid` and its operands steady until a clock edge where both are high; that edge is the acceptance. The result side has no back-pressure. `out_valid` pulses for exactly one cycle, and the result fields keep their value until the next pulse. A sink that needs the value later can read it at any time before then.

Top module: `bcd_addsub`

## Requirements
- R1: An offer is accepted on a rising edge where both `in_valid` and `in_ready` are high. After an accepted offer whose digits are all legal, `in_ready` stays low until the cycle in which `out_valid` is high. While it is low, `out_valid` stays low.
- R2: With `in_sub` = 0, `out_mag` is (A + B) mod 10^DIGITS in packed decimal, with `out_neg` = 0. Each digit is corrected by adding 6 when its raw sum exceeds 9. `out_valid` rises DIGITS+1 rising edges after acceptance, counting the acceptance edge as the first.
- R3: With `in_sub` = 0, `out_ovf` is 1 exactly when A + B exceeds 10^DIGITS − 1. With `in_sub` = 1, `out_ovf` is 0.
- R4: With `in_sub` = 1 and A > B, `out_mag` is A − B and `out_neg` is 0. The carry out of the top digit is fed back into the lowest digit in a second pass over the digits, so `out_valid` rises 2·DIGITS+1 edges after acceptance.
- R5: With `in_sub` = 1 and A < B, `out_mag` is B − A, formed as the nines' complement of the digit sum, and `out_neg` is 1. `out_valid` rises DIGITS+1 edges after acceptance.
- R6: With `in_sub` = 1 and A = B, `out_mag` is zero and `out_neg` is 0, so there is no negative zero. `out_valid` rises DIGITS+1 edges after acceptance.
- R7: If any nibble of `in_a` or `in_b` holds a value from 10 to 15, the offer is accepted but not computed. In that case `out_valid` and `out_bad` are high on the cycle after acceptance, `out_mag`, `out_neg` and `out_ovf` keep their previous values, and `in_ready` stays high. A computed result clears `out_bad`.
- R8: `out_mag`, `out_neg`, `out_ovf` and `out_bad` change only together with an `out_valid` pulse. Every nibble of `out_mag` is a legal decimal digit (0 to 9).
- R9: While `rst_n` is low at a rising edge, the block returns to idle. `in_ready` is then 1, and `out_valid`, `out_mag`, `out_neg`, `out_ovf` and `out_bad` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Block idle; offer will be accepted |
| in_a | input | 4·DIGITS | First operand, packed decimal, lowest digit in bits 3:0 |
| in_b | input | 4·DIGITS | Second operand (subtrahend when subtracting), packed decimal |
| in_sub | input | 1 | 1 = A − B, 0 = A + B |
| out_valid | output | 1 | One-cycle result strobe |
| out_mag | output | 4·DIGITS | Result magnitude, packed decimal |
| out_neg | output | 1 | Result is negative |
| out_ovf | output | 1 | Addition carried out of the top digit |
| out_bad | output | 1 | Last offer held an illegal digit |

## Verification
The assertions take for granted only that the inputs are free of unknowns once reset is released. They do not assume that the operand digits are legal. The digit-range and no-negative-zero properties rest on the screening done at acceptance, so the stimulus deliberately mixes in nibbles from 10 to 15, including back-to-back illegal offers. The stimulus keeps each offer steady until it is taken and holds offers through busy periods to exercise the back-pressure rule. It covers A above, below and equal to B, and sums that correct every digit or carry out of the top one.

// File: rtl/bcd_pkg.sv
package bcd_pkg;
  localparam int DIG_W = 4;
  localparam logic [DIG_W-1:0] DIG_MAX = 4'd9;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_RIPPLE = 2'd1,
    ST_WRAP   = 2'd2
  } seq_st_t;
endpackage

// File: rtl/bcd_digit_add.sv
module bcd_digit_add
  import bcd_pkg::*;
(
  input  logic [DIG_W-1:0] a,
  input  logic [DIG_W-1:0] b,
  input  logic             cin,
  output logic [DIG_W-1:0] s,
  output logic             cout
);
  logic [DIG_W:0] raw;
  logic           fix;

  always_comb begin
    raw  = {1'b0, a} + {1'b0, b} + {{DIG_W{1'b0}}, cin};
    // decimal correction: any raw value of ten or more wraps by six
    fix  = (raw > {1'b0, DIG_MAX});
    s    = fix ? (raw[DIG_W-1:0] + 4'd6) : raw[DIG_W-1:0];
    cout = fix;
  end
endmodule

// File: rtl/bcd_nines.sv
module bcd_nines
  import bcd_pkg::*;
#(
  parameter int DIGITS = 3
) (
  input  logic [DIGITS*DIG_W-1:0] d,
  input  logic                    en,
  output logic [DIGITS*DIG_W-1:0] q
);
  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    assign q[g*DIG_W +: DIG_W] = en ? (DIG_MAX - d[g*DIG_W +: DIG_W])
                                    : d[g*DIG_W +: DIG_W];
  end
endmodule

// File: rtl/bcd_digit_screen.sv
module bcd_digit_screen
  import bcd_pkg::*;
#(
  parameter int DIGITS = 3
) (
  input  logic [DIGITS*DIG_W-1:0] d,
  output logic                    ok
);
  logic [DIGITS-1:0] legal;

  for (genvar g = 0; g < DIGITS; g++) begin : g_dig
    assign legal[g] = (d[g*DIG_W +: DIG_W] <= DIG_MAX);
  end

  assign ok = &legal;
endmodule

// File: rtl/bcd_addsub.sv
module bcd_addsub
  import bcd_pkg::*;
#(
  parameter int DIGITS = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic [DIGITS*DIG_W-1:0] in_a,
  input  logic [DIGITS*DIG_W-1:0] in_b,
  input  logic                    in_sub,
  output logic                    out_valid,
  output logic [DIGITS*DIG_W-1:0] out_mag,
  output logic                    out_neg,
  output logic                    out_ovf,
  output logic                    out_bad
);
  localparam int W     = DIGITS * DIG_W;
  localparam int IDX_W = (DIGITS > 1) ? $clog2(DIGITS) : 1;
  localparam int LAST  = DIGITS - 1;

  seq_st_t          st_q;
  logic [W-1:0]     opa_q, opb_q, acc_q, acc_nx;
  logic             sub_q, carry_q;
  logic [IDX_W-1:0] idx_q;

  logic [W-1:0]     b_eff, comp;
  logic             a_ok, b_ok, ops_ok, mag_ok, at_last;
  logic [DIG_W-1:0] dig_a, dig_b, dsum;
  logic             dcout;

  // operand screening and subtrahend conditioning at the input
  bcd_digit_screen #(.DIGITS(DIGITS)) u_scr_a (.d(in_a), .ok(a_ok));
  bcd_digit_screen #(.DIGITS(DIGITS)) u_scr_b (.d(in_b), .ok(b_ok));
  bcd_nines #(.DIGITS(DIGITS)) u_sub_comp (.d(in_b), .en(in_sub), .q(b_eff));

  assign ops_ok   = a_ok & b_ok;
  assign in_ready = (st_q == ST_IDLE);
  assign at_last  = (idx_q == IDX_W'(LAST));

  // one digit slice, time-shared over all digit positions
  always_comb begin
    if (st_q == ST_WRAP) begin
      dig_a = acc_q[idx_q*DIG_W +: DIG_W];
      dig_b = '0;
    end else begin
      dig_a = opa_q[idx_q*DIG_W +: DIG_W];
      dig_b = opb_q[idx_q*DIG_W +: DIG_W];
    end
  end

  bcd_digit_add u_slice (
    .a(dig_a), .b(dig_b), .cin(carry_q), .s(dsum), .cout(dcout)
  );

  always_comb begin
    acc_nx = acc_q;
    acc_nx[idx_q*DIG_W +: DIG_W] = dsum;
  end

  // magnitude of a negative difference
  bcd_nines #(.DIGITS(DIGITS)) u_neg_comp (.d(acc_nx), .en(1'b1), .q(comp));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q      <= ST_IDLE;
      opa_q     <= '0;
      opb_q     <= '0;
      acc_q     <= '0;
      sub_q     <= 1'b0;
      carry_q   <= 1'b0;
      idx_q     <= '0;
      out_valid <= 1'b0;
      out_mag   <= '0;
      out_neg   <= 1'b0;
      out_ovf   <= 1'b0;
      out_bad   <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (in_valid) begin
            if (ops_ok) begin
              opa_q   <= in_a;
              opb_q   <= b_eff;
              sub_q   <= in_sub;
              acc_q   <= '0;
              carry_q <= 1'b0;
              idx_q   <= '0;
              st_q    <= ST_RIPPLE;
            end else begin
              out_valid <= 1'b1;
              out_bad   <= 1'b1;
            end
          end
        end
        ST_RIPPLE: begin
          acc_q   <= acc_nx;
          carry_q <= dcout;
          idx_q   <= idx_q + 1'b1;
          if (at_last) begin
            idx_q <= '0;
            if (sub_q && dcout) begin
              // end-around carry: feed the top carry back into digit zero
              st_q    <= ST_WRAP;
              carry_q <= 1'b1;
            end else begin
              st_q      <= ST_IDLE;
              out_valid <= 1'b1;
              out_bad   <= 1'b0;
              if (sub_q) begin
                out_mag <= comp;
                out_neg <= |comp;
                out_ovf <= 1'b0;
              end else begin
                out_mag <= acc_nx;
                out_neg <= 1'b0;
                out_ovf <= dcout;
              end
            end
          end
        end
        ST_WRAP: begin
          acc_q   <= acc_nx;
          carry_q <= dcout;
          idx_q   <= idx_q + 1'b1;
          if (at_last) begin
            idx_q     <= '0;
            st_q      <= ST_IDLE;
            out_valid <= 1'b1;
            out_bad   <= 1'b0;
            out_mag   <= acc_nx;
            out_neg   <= 1'b0;
            out_ovf   <= 1'b0;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  bcd_digit_screen #(.DIGITS(DIGITS)) u_scr_out (.d(out_mag), .ok(mag_ok));

  p_busy_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |-> !out_valid);

  p_accept_busy_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && ops_ok) |=> !in_ready);

  p_slice_digit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_IDLE) |-> (dsum <= DIG_MAX));

  p_ovf_add_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_bad && out_ovf) |-> !sub_q);

  p_wrap_sub_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_WRAP) |-> sub_q);

  p_sign_excl_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_neg && out_ovf));

  p_no_neg_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_neg) |-> (out_mag != '0));

  p_bad_holds_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_bad) |-> ($stable(out_mag) && $stable(out_neg) && $stable(out_ovf)));

  p_bad_stays_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !ops_ok) |=> in_ready);

  p_legal_digits_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> mag_ok);

  p_quiet_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_mag) && $stable(out_neg) && $stable(out_bad)));
endmodule

// File: tb/bcd_addsub_bench.sv
module bcd_addsub_bench;
  localparam int DIGITS = 3;
  localparam int W      = DIGITS * 4;
  localparam int LIMIT  = 1000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [W-1:0] in_a = '0, in_b = '0;
  logic         in_sub = 1'b0;
  logic         in_ready, out_valid, out_neg, out_ovf, out_bad;
  logic [W-1:0] out_mag;

  always #2 clk = ~clk;

  bcd_addsub #(.DIGITS(DIGITS)) u_bcd_addsub (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_a(in_a), .in_b(in_b), .in_sub(in_sub), .out_valid(out_valid),
    .out_mag(out_mag), .out_neg(out_neg), .out_ovf(out_ovf), .out_bad(out_bad)
  );

  int    checks = 0, fails = 0, cyc = 0;
  int    cd = -1;
  bit    busy = 0;
  int    exp_mag = 0; bit exp_neg = 0, exp_ovf = 0, exp_bad = 0;
  int    p_mag = 0;   bit p_neg = 0, p_ovf = 0, p_bad = 0;
  string tag = "R9";
  bit    done_flag = 0;

  function automatic logic [W-1:0] to_bcd(input int v);
    logic [W-1:0] r = '0;
    for (int i = 0; i < DIGITS; i++) begin
      r[i*4 +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return r;
  endfunction

  function automatic bit has_bad(input logic [W-1:0] x);
    for (int i = 0; i < DIGITS; i++) if (x[i*4 +: 4] > 4'd9) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int from_bcd(input logic [W-1:0] x);
    int v = 0;
    for (int i = DIGITS - 1; i >= 0; i--) v = v * 10 + int'(x[i*4 +: 4]);
    return v;
  endfunction

  task automatic chk(input bit ok, input string t, input string what,
                     input longint act, input longint expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", t, what, act, expv);
    end
  endtask

  // one clock: observe at the falling edge, then drive the next inputs
  task automatic step(input bit v, input logic [W-1:0] a, input logic [W-1:0] b,
                      input bit sub, output bit taken);
    bit    exp_ov, exp_rdy;
    string t;
    @(negedge clk);
    exp_ov  = (cd == 0);
    exp_rdy = !(busy && cd != 0);
    if (exp_ov) begin
      exp_mag = p_mag; exp_neg = p_neg; exp_ovf = p_ovf; exp_bad = p_bad;
    end
    t = exp_ov ? tag : "R8";
    chk(out_valid == exp_ov, exp_ov ? tag : "R1", "out_valid", out_valid, exp_ov);
    chk(in_ready == exp_rdy, "R1", "in_ready", in_ready, exp_rdy);
    chk(out_mag == to_bcd(exp_mag), t, "out_mag", out_mag, to_bcd(exp_mag));
    chk(out_neg == exp_neg, t, "out_neg", out_neg, exp_neg);
    chk(out_ovf == exp_ovf, t, "out_ovf", out_ovf, exp_ovf);
    chk(out_bad == exp_bad, t, "out_bad", out_bad, exp_bad);
    if (cd == 0) busy = 0;
    if (cd >= 0) cd--;
    in_valid = v; in_a = a; in_b = b; in_sub = sub;
    taken = v && in_ready;
    if (taken) begin
      int av, bv, lat;
      if (has_bad(a) || has_bad(b)) begin
        lat = 1; tag = "R7";
        p_mag = exp_mag; p_neg = exp_neg; p_ovf = exp_ovf; p_bad = 1;
      end else begin
        av = from_bcd(a); bv = from_bcd(b); p_bad = 0;
        if (!sub) begin
          lat = DIGITS + 1;
          p_mag = (av + bv) % LIMIT; p_neg = 0; p_ovf = (av + bv) >= LIMIT;
          tag = p_ovf ? "R3" : "R2";
        end else if (av > bv) begin
          lat = 2 * DIGITS + 1; tag = "R4";
          p_mag = av - bv; p_neg = 0; p_ovf = 0;
        end else if (av < bv) begin
          lat = DIGITS + 1; tag = "R5";
          p_mag = bv - av; p_neg = 1; p_ovf = 0;
        end else begin
          lat = DIGITS + 1; tag = "R6";
          p_mag = 0; p_neg = 0; p_ovf = 0;
        end
        busy = 1;
      end
      cd = lat - 1;
    end
  endtask

  task automatic offer(input logic [W-1:0] a, input logic [W-1:0] b, input bit sub);
    bit taken = 0;
    for (int n = 0; n < 40 && !taken; n++) step(1'b1, a, b, sub, taken);
    if (!taken) chk(1'b0, "R1", "offer never accepted", 0, 1);
  endtask

  task automatic idle(input int n);
    bit taken;
    for (int i = 0; i < n; i++) step(1'b0, '0, '0, 1'b0, taken);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL R1 watchdog actual=%0d expected=%0d", cyc, 150000);
      finish_run();
    end
  end

  initial begin
    // R9: reset state
    repeat (2) @(negedge clk);
    chk(in_ready == 1'b1, "R9", "in_ready", in_ready, 1);
    chk(out_valid == 1'b0, "R9", "out_valid", out_valid, 0);
    chk(out_mag == '0, "R9", "out_mag", out_mag, 0);
    chk({out_neg, out_ovf, out_bad} == 3'b000, "R9", "flags", {out_neg, out_ovf, out_bad}, 0);
    rst_n = 1'b1;

    offer(12'h068, 12'h024, 1); idle(8);   // R4: end-around gives 044
    offer(12'h024, 12'h068, 1); idle(5);   // R5: magnitude 044, negative
    offer(12'h024, 12'h024, 1); idle(5);   // R6: zero, not negative
    offer(12'h123, 12'h456, 0); idle(5);   // R2
    offer(12'h089, 12'h011, 0); idle(5);   // R2: correction chain to 100
    offer(12'h555, 12'h555, 0); idle(5);   // R3: carry out of top digit
    offer(12'h999, 12'h001, 0); idle(5);   // R3: wraps to 000
    offer(12'h0A0, 12'h001, 0);            // R7: illegal digit in A
    offer(12'h123, 12'h00F, 1); idle(3);   // R7: back-to-back illegal
    offer(12'h000, 12'h999, 1); idle(5);   // R5
    offer(12'h999, 12'h000, 1); idle(8);   // R4
    offer(12'h500, 12'h499, 1);            // R4: held offer after busy
    offer(12'h001, 12'h002, 1); idle(5);   // R1: accepted only when ready

    for (int k = 0; k < 400; k++) begin
      logic [W-1:0] a, b;
      a = to_bcd(int'($urandom_range(0, LIMIT - 1)));
      b = to_bcd(int'($urandom_range(0, LIMIT - 1)));
      if ($urandom_range(0, 9) == 0) a[$urandom_range(0, DIGITS - 1)*4 +: 4] = 4'($urandom_range(10, 15));
      if ($urandom_range(0, 9) == 0) b[$urandom_range(0, DIGITS - 1)*4 +: 4] = 4'($urandom_range(10, 15));
      offer(a, b, 1'($urandom_range(0, 1)));
      idle(int'($urandom_range(0, 3)));
    end
    idle(10);
    finish_run();
  end
endmodule